// File: doc/BRIEF.md
# Stereo Audio Serial Port (Bit-Clock Slave)

This block moves stereo audio samples between a parallel core interface and a three-wire serial link whose bit clock and word clock are driven by an external master. It oversamples the bit clock, the word clock and the serial input in its own system clock domain. It finds bit-clock edges and frame boundaries there, shifts a left and a right sample out on `sdout` in every frame, and captures a left and a right sample from `sdin`.

One shared position counter and one slot decoder serve four framings: I2S, left-aligned, right-aligned and a DSP-style framing in which both words follow one frame marker back to back. The word length is selectable. A bit-clock offset can delay the first bit in the left-aligned and DSP framings. The transmit side takes a new sample pair once per frame through a valid/ready pair. If the core has no pair ready at that moment, the port repeats the previous pair and flags an underrun. The receive side presents each captured pair with a one-cycle valid strobe.

Top module: `audio_serial_port`

## Requirements
- R1: With `cfg_fmt`=0 (I2S), the left half is the word-clock-low half. In each half the MSB occupies the second bit clock after the word-clock transition (position 1, where position 0 is the first rising bit-clock edge after the transition), and the remaining bits follow MSB first.
- R2: With `cfg_fmt`=1 (left-aligned), the left half is the word-clock-high half. In each half the MSB occupies position `cfg_offset`.
- R3: With `cfg_fmt`=2 (right-aligned), the left half is the word-clock-high half. The LSB of each word occupies the last bit clock of its half. The half length is taken from the length of the half before it.
- R4: With `cfg_fmt`=3 (DSP), a frame starts at the first rising bit-clock edge that sees the word clock high (position 0). The word clock may be a one-bit-clock pulse or a square wave. The left MSB sits at position `cfg_offset`, and the right MSB follows directly after the left LSB.
- R5: `cfg_wlen` selects the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. Samples are right-aligned on the parallel buses. Transmit bits above the word length are ignored. `sdout` is 0 in every bit clock outside a data window. Received words are zero-extended, and `sdin` outside a window is ignored.
- R6: After the right word of a frame is captured, `rx_valid` is high for exactly one clock, with `rx_left` and `rx_right` holding that frame's words.
- R7: `tx_ready` is high for exactly one clock at each frame start once the port is in step. A pair on `tx_left`/`tx_right` is taken when `tx_valid` is high in that clock, and it is sent in that frame.
- R8: If `tx_valid` is low at a frame start, the previous pair is sent again, and `tx_underrun` pulses for one clock.
- R9: After reset, `sdout` stays 0, and `rx_valid`, `tx_ready` and `tx_underrun` stay low, until a frame start that has at least one earlier word-clock level change behind it.
- R10: `sdout` changes only in the clock after a falling bit-clock edge is detected. Input bits are taken on detected rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-aligned, 2 right-aligned, 3 DSP |
| cfg_wlen | input | 2 | Word length code (16/20/24/32) |
| cfg_offset | input | OFF_W | Data offset in bit clocks (left-aligned and DSP) |
| bclk | input | 1 | External bit clock |
| wclk | input | 1 | External word clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out |
| tx_left | input | 32 | Left transmit sample, right-aligned |
| tx_right | input | 32 | Right transmit sample, right-aligned |
| tx_valid | input | 1 | Transmit pair available |
| tx_ready | output | 1 | Frame start: the pair is taken if valid |
| tx_underrun | output | 1 | Pulse: no pair at frame start, last pair repeated |
| rx_left | output | 32 | Received left sample |
| rx_right | output | 32 | Received right sample |
| rx_valid | output | 1 | One-clock strobe: new received pair |

## Verification
A wrong position count or a wrong half flag puts the very next data window on the wrong bit clocks. It therefore shows up on `sdout` within one bit clock of the first shifted bit, and in the word reported at the next `rx_valid`. A hold register that is loaded at the wrong moment shows up as a wrong or stale word across a whole frame, and a wrong sync flag shows up as early activity in the first frame after reset. The bench compares `sdout` against its own model at every rising bit-clock edge. It also checks every received pair and counts the handshakes and underruns in each run.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int unsigned SAMPLE_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_DSP   = 2'd3
  } asp_fmt_e;

  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/asp_frame_track.sv
module asp_frame_track import asp_pkg::*; #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_s,
  input  logic             wclk_s,
  input  asp_fmt_e         fmt,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             frame_start,
  output logic             drive_en,
  output logic             synced,
  output logic             half_right,
  output logic [POS_W-1:0] pos,
  output logic [POS_W:0]   half_len
);
  logic             bclk_q;
  logic             have_q, have_n;
  logic             lvl_q, lvl_n;
  logic             seen_q, seen_n;
  logic             half_n, sync_n;
  logic [POS_W-1:0] pos_n;
  logic [POS_W:0]   len_n;
  logic             is_dsp, left_lvl, chg, bnd;

  always_comb begin
    rise_ev  = ~bclk_q & bclk_s;
    fall_ev  = bclk_q & ~bclk_s;
    is_dsp   = (fmt == FMT_DSP);
    left_lvl = (fmt != FMT_I2S);
    chg      = have_q & (wclk_s ^ lvl_q);
    bnd      = chg & (~is_dsp | wclk_s);
    frame_start = fall_ev & bnd & (wclk_s == left_lvl) & seen_q;

    have_n = have_q;
    lvl_n  = lvl_q;
    seen_n = seen_q;
    half_n = half_right;
    sync_n = synced;
    pos_n  = pos;
    len_n  = half_len;
    if (fall_ev) begin
      have_n = 1'b1;
      lvl_n  = wclk_s;
      if (chg) seen_n = 1'b1;
      if (bnd) begin
        pos_n  = '0;
        half_n = (wclk_s != left_lvl);
        len_n  = {1'b0, pos} + (POS_W+1)'(1);
      end else if (pos != {POS_W{1'b1}}) begin
        pos_n = pos + POS_W'(1);
      end
      if (frame_start) sync_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      have_q     <= 1'b0;
      lvl_q      <= 1'b0;
      seen_q     <= 1'b0;
      half_right <= 1'b0;
      synced     <= 1'b0;
      pos        <= '0;
      half_len   <= '0;
      drive_en   <= 1'b0;
    end else begin
      bclk_q     <= bclk_s;
      have_q     <= have_n;
      lvl_q      <= lvl_n;
      seen_q     <= seen_n;
      half_right <= half_n;
      synced     <= sync_n;
      pos        <= pos_n;
      half_len   <= len_n;
      drive_en   <= fall_ev;
    end
  end
endmodule

// File: rtl/asp_slot_map.sv
module asp_slot_map import asp_pkg::*; #(
  parameter int POS_W = 9,
  parameter int OFF_W = 5
) (
  input  asp_fmt_e         fmt,
  input  logic [1:0]       wlen,
  input  logic [OFF_W-1:0] offset,
  input  logic [POS_W-1:0] pos,
  input  logic             half_right,
  input  logic [POS_W:0]   half_len,
  output logic             active,
  output logic             chan_right,
  output logic             first,
  output logic             last,
  output logic [4:0]       bit_sel
);
  localparam int CW = POS_W + 2;

  logic [CW-1:0] p, wl, off, hl, start, rel;

  always_comb begin
    p   = CW'(pos);
    wl  = CW'(word_bits(wlen));
    off = CW'(offset);
    hl  = CW'(half_len);
    chan_right = half_right;
    case (fmt)
      FMT_I2S:   start = CW'(1);
      FMT_LEFT:  start = off;
      FMT_RIGHT: start = (hl >= wl) ? (hl - wl) : '0;
      default: begin
        chan_right = (p >= off + wl);
        start      = chan_right ? (off + wl) : off;
      end
    endcase
    rel     = p - start;
    active  = (p >= start) && (p < start + wl);
    first   = (rel == '0);
    last    = (rel == wl - CW'(1));
    bit_sel = 5'(wl - CW'(1) - rel);
  end
endmodule

// File: rtl/asp_tx_path.sv
module asp_tx_path import asp_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                tx_valid,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  input  logic                drive_en,
  input  logic                synced,
  input  logic                active,
  input  logic                chan_right,
  input  logic [4:0]          bit_sel,
  output logic                sdout,
  output logic                underrun
);
  logic [SAMPLE_W-1:0] hold_l, hold_r, hold_l_n, hold_r_n, word;
  logic                sd_n, ur_n;

  always_comb begin
    hold_l_n = hold_l;
    hold_r_n = hold_r;
    if (load && tx_valid) begin
      hold_l_n = tx_left;
      hold_r_n = tx_right;
    end
    ur_n = load && !tx_valid;
    word = chan_right ? hold_r : hold_l;
    sd_n = drive_en ? (synced && active && word[bit_sel]) : sdout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l   <= '0;
      hold_r   <= '0;
      sdout    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      hold_l   <= hold_l_n;
      hold_r   <= hold_r_n;
      sdout    <= sd_n;
      underrun <= ur_n;
    end
  end
endmodule

// File: rtl/asp_rx_path.sv
module asp_rx_path import asp_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_ev,
  input  logic                synced,
  input  logic                active,
  input  logic                chan_right,
  input  logic                first,
  input  logic                last,
  input  logic                sdin_s,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_valid
);
  logic [SAMPLE_W-1:0] sh, sh_n, lhold, lhold_n, rl_n, rr_n, shifted;
  logic                vld_n;

  always_comb begin
    shifted = first ? {{(SAMPLE_W-1){1'b0}}, sdin_s} : {sh[SAMPLE_W-2:0], sdin_s};
    sh_n    = sh;
    lhold_n = lhold;
    rl_n    = rx_left;
    rr_n    = rx_right;
    vld_n   = 1'b0;
    if (rise_ev && synced && active) begin
      sh_n = shifted;
      if (last) begin
        if (chan_right) begin
          rl_n  = lhold;
          rr_n  = shifted;
          vld_n = 1'b1;
        end else begin
          lhold_n = shifted;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      lhold    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      sh       <= sh_n;
      lhold    <= lhold_n;
      rx_left  <= rl_n;
      rx_right <= rr_n;
      rx_valid <= vld_n;
    end
  end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port import asp_pkg::*; #(
  parameter int POS_W       = 9,
  parameter int OFF_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_wlen,
  input  logic [OFF_W-1:0]    cfg_offset,
  input  logic                bclk,
  input  logic                wclk,
  input  logic                sdin,
  output logic                sdout,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                tx_underrun,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_valid
);
  logic             rst_int_n;
  logic [2:0]       pins_s;
  logic             rise_ev, fall_ev, frame_start, drive_en, synced, half_right;
  logic [POS_W-1:0] pos;
  logic [POS_W:0]   half_len;
  logic             active, chan_right, first, last;
  logic [4:0]       bit_sel;
  asp_fmt_e         fmt;

  assign fmt = asp_fmt_e'(cfg_fmt);

  asp_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  asp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .d({bclk, wclk, sdin}), .q(pins_s)
  );

  asp_frame_track #(.POS_W(POS_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .bclk_s(pins_s[2]), .wclk_s(pins_s[1]),
    .fmt(fmt), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .frame_start(frame_start), .drive_en(drive_en), .synced(synced),
    .half_right(half_right), .pos(pos), .half_len(half_len)
  );

  asp_slot_map #(.POS_W(POS_W), .OFF_W(OFF_W)) u_slot (
    .fmt(fmt), .wlen(cfg_wlen), .offset(cfg_offset), .pos(pos),
    .half_right(half_right), .half_len(half_len), .active(active),
    .chan_right(chan_right), .first(first), .last(last), .bit_sel(bit_sel)
  );

  asp_tx_path u_tx (
    .clk(clk), .rst_n(rst_int_n), .load(frame_start), .tx_valid(tx_valid),
    .tx_left(tx_left), .tx_right(tx_right), .drive_en(drive_en),
    .synced(synced), .active(active), .chan_right(chan_right),
    .bit_sel(bit_sel), .sdout(sdout), .underrun(tx_underrun)
  );

  asp_rx_path u_rx (
    .clk(clk), .rst_n(rst_int_n), .rise_ev(rise_ev), .synced(synced),
    .active(active), .chan_right(chan_right), .first(first), .last(last),
    .sdin_s(pins_s[0]), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid)
  );

  assign tx_ready = frame_start;
endmodule

// File: rtl/asp_checker.sv
module asp_checker import asp_pkg::*; (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          cfg_wlen,
  input logic                sdout,
  input logic                tx_ready,
  input logic                tx_valid,
  input logic                tx_underrun,
  input logic                rx_valid,
  input logic [SAMPLE_W-1:0] rx_left,
  input logic [SAMPLE_W-1:0] rx_right,
  input logic                synced,
  input logic                drive_en
);
  logic [SAMPLE_W-1:0] keep;
  logic [5:0]          wl;

  always_comb begin
    wl   = word_bits(cfg_wlen);
    keep = (wl >= 6'(SAMPLE_W)) ? '1 : ((SAMPLE_W'(1) << wl) - SAMPLE_W'(1));
  end

  a_r5_rx_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (((rx_left & ~keep) == '0) && ((rx_right & ~keep) == '0)));

  a_r6_rx_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  a_r8_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && !tx_valid |=> tx_underrun);

  a_r9_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!sdout && !rx_valid && !tx_underrun));

  a_r10_sdout_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> $stable(sdout));
endmodule

bind audio_serial_port asp_checker u_chk (
  .clk(clk), .rst_n(rst_int_n), .cfg_wlen(cfg_wlen), .sdout(sdout),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_underrun(tx_underrun),
  .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right),
  .synced(synced), .drive_en(drive_en)
);

// File: tb/tb_audio_serial_port.sv
module tb_audio_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int BCLK_HALF  = 6;

  logic        clk, rst_n;
  logic [1:0]  cfg_fmt, cfg_wlen;
  logic [4:0]  cfg_offset;
  logic        bclk, wclk, sdin, sdout;
  logic [31:0] tx_left, tx_right, rx_left, rx_right;
  logic        tx_valid, tx_ready, tx_underrun, rx_valid;

  int n_checks = 0, n_fail = 0;
  int acc_cnt = 0, ur_cnt = 0, rdy_cnt = 0;
  logic rx_prev = 1'b0;
  logic [63:0] exp_q[$];
  bit done = 0;

  audio_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
    .cfg_offset(cfg_offset), .bclk(bclk), .wclk(wclk), .sdin(sdin),
    .sdout(sdout), .tx_left(tx_left), .tx_right(tx_right),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Port monitor, sampled on the falling system-clock edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_ready && tx_valid) acc_cnt++;
      if (tx_ready) rdy_cnt++;
      if (tx_underrun) ur_cnt++;
      if (rx_valid) begin
        check(!rx_prev, "R6 rx_valid single clock", 64'(rx_prev), 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 rx_valid before sync", 64'd1, 64'd0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(rx_left == e[63:32], "R6 R5 rx_left word", 64'(rx_left), 64'(e[63:32]));
          check(rx_right == e[31:0], "R6 R5 rx_right word", 64'(rx_right), 64'(e[31:0]));
        end
      end
      rx_prev = rx_valid;
    end
  end

  function automatic int wl_of(input int code);
    case (code)
      0: return 16;
      1: return 20;
      2: return 24;
      default: return 32;
    endcase
  endfunction

  // One bit clock: falling edge with new wclk/sdin, then check sdout before the rise.
  task automatic bit_clock(input logic w, input logic d, input logic e,
                           input string tag, input bit drop_valid);
    @(negedge clk);
    bclk = 1'b0; wclk = w; sdin = d;
    repeat (BCLK_HALF) @(negedge clk);
    check(sdout === e, tag, 64'(sdout), 64'(e));
    if (drop_valid) tx_valid = 1'b0;
    bclk = 1'b1;
    repeat (BCLK_HALF-1) @(negedge clk);
  endtask

  task automatic run(input int fmt, input int wcode, input int off, input int hlen,
                     input int nfr, input bit pulse, input int ur_frame, input string tag);
    int wl, exp_acc, exp_ur, acc0, ur0, rdy0;
    logic left_lvl;
    logic [31:0] cur_l, cur_r, rl, rr, mask;
    wl = wl_of(wcode);
    mask = (wl == 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
    left_lvl = (fmt != 0);
    cfg_fmt = 2'(fmt); cfg_wlen = 2'(wcode); cfg_offset = 5'(off);
    tx_valid = 1'b0; bclk = 1'b1; wclk = (fmt == 3) ? 1'b0 : ~left_lvl; sdin = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!sdout && !tx_ready && !rx_valid && !tx_underrun, "R9 reset state",
          {60'd0, sdout, tx_ready, rx_valid, tx_underrun}, 64'd0);
    acc0 = acc_cnt; ur0 = ur_cnt; rdy0 = rdy_cnt;
    exp_acc = 0; exp_ur = 0; cur_l = '0; cur_r = '0;
    for (int i = 0; i < 3; i++)
      bit_clock((fmt == 3) ? 1'b0 : ~left_lvl, 1'($urandom), 1'b0, "R9 lead-in quiet", 1'b0);
    for (int f = 0; f < nfr; f++) begin
      if (f >= 1 && f != ur_frame) begin
        cur_l = $urandom; cur_r = $urandom;
        tx_left = cur_l; tx_right = cur_r; tx_valid = 1'b1; exp_acc++;
      end else if (f == ur_frame) begin
        tx_left = $urandom; tx_right = $urandom; tx_valid = 1'b0; exp_ur++;
      end
      rl = $urandom; rr = $urandom;
      if (f >= 1) exp_q.push_back({rl & mask, rr & mask});
      for (int p = 0; p < 2*hlen; p++) begin
        logic w, right, inwin, d, e;
        int q, start, b;
        if (fmt == 3) begin
          w = pulse ? (p == 0) : (p < hlen);
          right = (p >= off + wl);
          start = right ? off + wl : off;
          q = p;
        end else begin
          right = (p >= hlen);
          w = right ? ~left_lvl : left_lvl;
          q = right ? p - hlen : p;
          start = (fmt == 0) ? 1 : (fmt == 1) ? off : hlen - wl;
        end
        inwin = (q >= start) && (q < start + wl);
        b = wl - 1 - (q - start);
        d = inwin ? (right ? rr[b] : rl[b]) : 1'($urandom);
        e = (f >= 1 && inwin) ? (right ? cur_r[b] : cur_l[b]) : 1'b0;
        bit_clock(w, d, e, (f == 0) ? "R9 first frame quiet" : tag, p == 0);
      end
    end
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R6 all received pairs reported", 64'(exp_q.size()), 64'd0);
    check(acc_cnt - acc0 == exp_acc, "R7 pairs accepted", 64'(acc_cnt - acc0), 64'(exp_acc));
    check(rdy_cnt - rdy0 == nfr - 1, "R7 R9 one ready per synced frame",
          64'(rdy_cnt - rdy0), 64'(nfr - 1));
    check(ur_cnt - ur0 == exp_ur, "R8 underrun pulses", 64'(ur_cnt - ur0), 64'(exp_ur));
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b1; wclk = 1'b0; sdin = 1'b0; tx_valid = 1'b0;
    tx_left = '0; tx_right = '0; cfg_fmt = '0; cfg_wlen = '0; cfg_offset = '0;
    run(0, 0, 0, 20, 4, 1'b0, 3,  "R1 R5 I2S 16-bit sdout");
    run(1, 2, 0, 32, 4, 1'b0, -1, "R2 R5 left-aligned 24-bit sdout");
    run(1, 1, 5, 32, 4, 1'b0, -1, "R2 left-aligned offset 5 sdout");
    run(2, 1, 0, 24, 4, 1'b0, -1, "R3 right-aligned 20-bit sdout");
    run(2, 3, 0, 32, 4, 1'b0, 2,  "R3 R8 right-aligned full-width sdout");
    run(3, 0, 0, 16, 4, 1'b1, -1, "R4 DSP pulse packed sdout");
    run(3, 2, 3, 32, 4, 1'b0, 2,  "R4 R8 DSP square offset 3 sdout");
    run(0, 3, 0, 33, 4, 1'b0, -1, "R1 R10 I2S 32-bit sdout");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule